// File: doc/BRIEF.md
# Load/Store and Branch Address Generator

This block forms the 32-bit effective address for a small RISC pipeline. A data access takes one of two forms. In the first, a sign-extended 16-bit displacement is added to a base. In the second, a second register value is added to the base. The base is the value of the first source register. When that register's index is zero, the base is literal zero instead. An unconditional immediate branch instead scales a 24-bit word offset by four and sign-extends it. It then adds the result either to the current instruction address or, for an absolute branch, to zero.

A caller presents its operands together with a one-cycle `start` strobe. One clock later the block returns the registered address with a one-cycle valid pulse. For data accesses it also returns a flag that shows whether the operand, given its byte length, runs past the top of the 4 GiB address space and wraps to address 0. All sums are taken modulo 2^32. The register file, the memory access itself, translation and branch-condition evaluation sit outside the block.

Top module: `addr_gen`

## Requirements
- R1: Mode encoding `mode[1:0]`: 0 selects displacement, 1 selects indexed, and 2 or 3 select immediate branch (mode bit 1 set means branch).
- R2: In displacement mode, the address is base + sign-extended `disp`. The base is `raVal`, or zero when `raIdx` is 0.
- R3: In indexed mode, the address is base + `rbVal`, with the base chosen as in R2.
- R4: Every address sum keeps only its low 32 bits, so results wrap modulo 2^32.
- R5: In branch mode the offset is `{branchImm, 2'b00}` sign-extended to 32 bits. It is added to `instAddr` when `absFlag` is 0 and to zero when `absFlag` is 1.
- R6: In branch mode, bits 1:0 of the result are always zero, whatever the value of `instAddr`.
- R7: In a data mode, `wrapFlag` is 1 exactly when address + `opLen` > 2^32, meaning the last operand byte lies past 0xFFFFFFFF. `opLen` is 1, 2, 4 or 8.
- R8: In branch mode, `wrapFlag` is 0.
- R9: `addrValid` is high in the cycle after each cycle in which `start` is high, and low otherwise. `effAddr` and `wrapFlag` carry that operation's result in the same cycle.
- R10: While `start` is low, the inputs are ignored and `effAddr` and `wrapFlag` keep their last values.
- R11: A synchronous active-high `rst` clears `effAddr`, `addrValid` and `wrapFlag` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Sample the operands this cycle |
| mode | input | 2 | Addressing mode (R1) |
| raIdx | input | 5 | Base register index; 0 means a base of zero |
| raVal | input | 32 | Base register value |
| rbVal | input | 32 | Index register value |
| disp | input | 16 | Signed displacement |
| branchImm | input | 24 | Signed branch word offset |
| absFlag | input | 1 | Branch is absolute |
| instAddr | input | 32 | Address of the current instruction |
| opLen | input | 4 | Data operand length in bytes |
| effAddr | output | 32 | Registered effective address |
| addrValid | output | 1 | Result strobe |
| wrapFlag | output | 1 | Data operand crosses the top of memory |

## Verification
Suppose the capture enable sits in the wrong state. Then `effAddr` either moves while `start` is low or misses an update, and the bench sees this at the very next sampled cycle. A wrong base or operand-selection path shows up as a wrong address in the single cycle of the valid pulse. The stimulus uses operand values chosen to separate zero base from register base, register index from displacement, and relative from absolute branches. The wrap comparison is probed at exact boundary lengths, where an off-by-one shows at once on `wrapFlag`.

// File: rtl/agen_pkg.sv
package agen_pkg;
  typedef enum logic [1:0] {
    AGEN_DISP     = 2'd0,
    AGEN_INDEX    = 2'd1,
    AGEN_BRANCH   = 2'd2,
    AGEN_BRANCH_B = 2'd3
  } agenMode_e;

  typedef struct packed {
    logic capture;
    logic clear;
  } agenCtrl_t;
endpackage

// File: rtl/agen_ctrl.sv
module agen_ctrl
  import agen_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      start,
  output agenCtrl_t ctrl,
  output logic      addrValid
);
  always_comb begin
    ctrl.clear   = rst;
    ctrl.capture = start & ~rst;
  end

  always_ff @(posedge clk) begin
    if (rst) addrValid <= 1'b0;
    else     addrValid <= start;
  end
endmodule

// File: rtl/agen_datapath.sv
module agen_datapath
  import agen_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 5,
  parameter int DISP_W = 16,
  parameter int IMM_W  = 24,
  parameter int LEN_W  = 4
) (
  input  logic              clk,
  input  agenCtrl_t         ctrl,
  input  logic [1:0]        mode,
  input  logic [IDX_W-1:0]  raIdx,
  input  logic [ADDR_W-1:0] raVal,
  input  logic [ADDR_W-1:0] rbVal,
  input  logic [DISP_W-1:0] disp,
  input  logic [IMM_W-1:0]  branchImm,
  input  logic              absFlag,
  input  logic [ADDR_W-1:0] instAddr,
  input  logic [LEN_W-1:0]  opLen,
  output logic [ADDR_W-1:0] effAddr,
  output logic              wrapFlag
);
  localparam int DISP_EXT = ADDR_W - DISP_W;
  localparam int OFF_W    = IMM_W + 2;
  localparam int SUM_W    = ADDR_W + 1;

  logic [ADDR_W-1:0] baseVal, dispExt, dataOperand, dataEa;
  logic [ADDR_W-1:0] branchOff, branchBase, branchEa, nextEa;
  logic [SUM_W-1:0]  endSum;
  logic              isBranch, nextWrap;

  assign isBranch = mode[1];
  assign dispExt  = {{DISP_EXT{disp[DISP_W-1]}}, disp};
  assign baseVal  = (raIdx == '0) ? '0 : raVal;

  generate
    if (OFF_W < ADDR_W) begin : g_offExt
      assign branchOff = {{(ADDR_W-OFF_W){branchImm[IMM_W-1]}}, branchImm, 2'b00};
    end else begin : g_offTrunc
      logic [OFF_W-1:0] offFull;
      assign offFull   = {branchImm, 2'b00};
      assign branchOff = offFull[ADDR_W-1:0];
    end
  endgenerate

  always_comb begin
    dataOperand = mode[0] ? rbVal : dispExt;
    dataEa      = baseVal + dataOperand;
    branchBase  = absFlag ? '0 : instAddr;
    branchEa    = (branchBase + branchOff) & ~ADDR_W'(3);
    nextEa      = isBranch ? branchEa : dataEa;
    endSum      = {1'b0, dataEa} + SUM_W'(opLen);
    nextWrap    = ~isBranch & endSum[ADDR_W] & (endSum[ADDR_W-1:0] != '0);
  end

  always_ff @(posedge clk) begin
    if (ctrl.clear) begin
      effAddr  <= '0;
      wrapFlag <= 1'b0;
    end else if (ctrl.capture) begin
      effAddr  <= nextEa;
      wrapFlag <= nextWrap;
    end
  end
endmodule

// File: rtl/addr_gen.sv
module addr_gen
  import agen_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 5,
  parameter int DISP_W = 16,
  parameter int IMM_W  = 24,
  parameter int LEN_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [1:0]        mode,
  input  logic [IDX_W-1:0]  raIdx,
  input  logic [ADDR_W-1:0] raVal,
  input  logic [ADDR_W-1:0] rbVal,
  input  logic [DISP_W-1:0] disp,
  input  logic [IMM_W-1:0]  branchImm,
  input  logic              absFlag,
  input  logic [ADDR_W-1:0] instAddr,
  input  logic [LEN_W-1:0]  opLen,
  output logic [ADDR_W-1:0] effAddr,
  output logic              addrValid,
  output logic              wrapFlag
);
  agenCtrl_t ctrl;

  agen_ctrl ctrl_i (
    .clk(clk), .rst(rst), .start(start), .ctrl(ctrl), .addrValid(addrValid)
  );

  agen_datapath #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .DISP_W(DISP_W), .IMM_W(IMM_W), .LEN_W(LEN_W)
  ) dp_i (
    .clk(clk), .ctrl(ctrl), .mode(mode), .raIdx(raIdx), .raVal(raVal),
    .rbVal(rbVal), .disp(disp), .branchImm(branchImm), .absFlag(absFlag),
    .instAddr(instAddr), .opLen(opLen), .effAddr(effAddr), .wrapFlag(wrapFlag)
  );
endmodule

// File: rtl/agen_checker.sv
module agen_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [1:0]        mode,
  input logic [ADDR_W-1:0] effAddr,
  input logic              addrValid,
  input logic              wrapFlag
);
  AST_VALID_AFTER_START: assert property (@(posedge clk) disable iff (rst)
    start |=> addrValid); // R9

  AST_VALID_NEEDS_START: assert property (@(posedge clk) disable iff (rst)
    addrValid |-> $past(start)); // R9

  AST_BRANCH_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    (addrValid && $past(mode[1])) |-> (effAddr[1:0] == 2'b00)); // R6

  AST_BRANCH_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (addrValid && $past(mode[1])) |-> !wrapFlag); // R8

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(start)) |-> ($stable(effAddr) && $stable(wrapFlag))); // R10
endmodule

bind addr_gen agen_checker #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst(rst), .start(start), .mode(mode), .effAddr(effAddr),
  .addrValid(addrValid), .wrapFlag(wrapFlag)
);

// File: tb/addr_gen_tb_top.sv
module addr_gen_tb_top;
  typedef struct {
    logic [31:0] addr;
    logic        wrap;
    string       req;
  } expItem_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [1:0]  mode = '0;
  logic [4:0]  raIdx = '0;
  logic [31:0] raVal = '0, rbVal = '0, instAddr = '0;
  logic [15:0] disp = '0;
  logic [23:0] branchImm = '0;
  logic        absFlag = 1'b0;
  logic [3:0]  opLen = 4'd1;
  logic [31:0] effAddr;
  logic        addrValid, wrapFlag;

  int checks = 0, failures = 0, cycles = 0;
  bit monOn = 0, finished = 0;
  expItem_t expQ[$];
  logic [31:0] lastAddr = '0;
  logic        lastWrap = 1'b0;

  always #10 clk = ~clk;

  addr_gen dut_i (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .raIdx(raIdx),
    .raVal(raVal), .rbVal(rbVal), .disp(disp), .branchImm(branchImm),
    .absFlag(absFlag), .instAddr(instAddr), .opLen(opLen),
    .effAddr(effAddr), .addrValid(addrValid), .wrapFlag(wrapFlag)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic expItem_t model(input logic [1:0] m, input logic [4:0] ri,
      input logic [31:0] ra, input logic [31:0] rb, input logic [15:0] d,
      input logic [23:0] imm, input logic ab, input logic [31:0] ia,
      input logic [3:0] len, input string req);
    expItem_t it;
    longint base, sum, off;
    base = (ri == 0) ? 0 : longint'(ra);
    if (m[1]) begin
      off = longint'($signed(imm)) * 4;
      sum = (ab ? 0 : longint'(ia)) + off;
      it.addr = sum[31:0] & 32'hFFFF_FFFC;
      it.wrap = 1'b0;
    end else begin
      sum = base + (m[0] ? longint'(rb) : longint'($signed(d)));
      it.addr = sum[31:0];
      it.wrap = (longint'(it.addr) + longint'(len)) > 64'h1_0000_0000;
    end
    it.req = req;
    return it;
  endfunction

  task automatic issue(input logic [1:0] m, input logic [4:0] ri, input logic [31:0] ra,
      input logic [31:0] rb, input logic [15:0] d, input logic [23:0] imm,
      input logic ab, input logic [31:0] ia, input logic [3:0] len, input string req);
    @(negedge clk);
    mode = m; raIdx = ri; raVal = ra; rbVal = rb; disp = d;
    branchImm = imm; absFlag = ab; instAddr = ia; opLen = len; start = 1'b1;
    expQ.push_back(model(m, ri, ra, rb, d, imm, ab, ia, len, req));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      start = 1'b0;
      mode = 2'(i); raIdx = 5'(i + 9); raVal = 32'hA5A5_0000 ^ i; rbVal = ~raVal;
      disp = 16'h8001; branchImm = 24'h7FFF01; absFlag = i[0];
      instAddr = 32'h1357_9BDF; opLen = 4'd8;
    end
  endtask

  // Monitor: pop expected results on valid, check holding otherwise
  always @(negedge clk) begin
    if (monOn && !rst) begin
      if (addrValid) begin
        if (expQ.size() == 0) begin
          check(0, "R9 unexpected valid", 64'(addrValid), 64'd0);
        end else begin
          expItem_t it;
          it = expQ.pop_front();
          check(effAddr === it.addr, {it.req, " address"}, 64'(effAddr), 64'(it.addr));
          check(wrapFlag === it.wrap, {it.req, " wrap flag"}, 64'(wrapFlag), 64'(it.wrap));
          lastAddr = effAddr;
          lastWrap = wrapFlag;
        end
      end else begin
        check(effAddr === lastAddr && wrapFlag === lastWrap, "R10 hold while idle",
              {31'd0, wrapFlag, effAddr}, {31'd0, lastWrap, lastAddr});
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !finished) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=<5000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    start = 1'b1;
    repeat (3) @(negedge clk);
    start = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    // R11: reset state, even with start high during reset
    check(effAddr === 0 && !addrValid && !wrapFlag, "R11 reset state",
          {30'd0, addrValid, wrapFlag, effAddr}, 64'd0);
    monOn = 1;

    // R2 displacement, negative, register base and zero base
    issue(2'd0, 5'd3, 32'h0000_1000, 32'h0, 16'hFFFC, 24'h0, 0, 32'h0, 4'd4, "R2 disp neg");
    issue(2'd0, 5'd0, 32'h0000_DEAD, 32'h0, 16'h0010, 24'h0, 0, 32'h0, 4'd4, "R2 zero base");
    idle(2);
    // R4 wrap of data sum
    issue(2'd0, 5'd1, 32'hFFFF_FFF0, 32'h0, 16'h0020, 24'h0, 0, 32'h0, 4'd8, "R4 disp modulo");
    // R7 boundary lengths
    issue(2'd0, 5'd2, 32'hFFFF_FFFC, 32'h0, 16'h0000, 24'h0, 0, 32'h0, 4'd4, "R7 ends at top");
    issue(2'd0, 5'd2, 32'hFFFF_FFFC, 32'h0, 16'h0000, 24'h0, 0, 32'h0, 4'd8, "R7 crosses top");
    issue(2'd0, 5'd2, 32'hFFFF_FFFF, 32'h0, 16'h0000, 24'h0, 0, 32'h0, 4'd1, "R7 last byte");
    issue(2'd1, 5'd2, 32'hFFFF_FF00, 32'hFF, 16'h0000, 24'h0, 0, 32'h0, 4'd2, "R7 index crosses");
    idle(3);
    // R3 indexed mode
    issue(2'd1, 5'd7, 32'h0000_0100, 32'h0000_0200, 16'h8000, 24'h0, 0, 32'h0, 4'd2, "R3 index");
    issue(2'd1, 5'd0, 32'h1111_1111, 32'h0000_0340, 16'h8000, 24'h0, 0, 32'h0, 4'd1, "R3 zero base");
    issue(2'd1, 5'd31, 32'hFFFF_FFFF, 32'h0000_0002, 16'h0, 24'h0, 0, 32'h0, 4'd1, "R4 index modulo");
    idle(1);
    // R5 branch relative/absolute, sign extension
    issue(2'd2, 5'd4, 32'h5, 32'h6, 16'h1, 24'hFF_FFFF, 0, 32'h0000_2000, 4'd8, "R5 rel back");
    issue(2'd2, 5'd4, 32'h5, 32'h6, 16'h1, 24'h00_0100, 1, 32'h0000_2000, 4'd8, "R5 absolute");
    issue(2'd2, 5'd4, 32'h5, 32'h6, 16'h1, 24'h80_0000, 1, 32'h0000_2000, 4'd8, "R5 abs neg");
    // R8 branch wrapping the space: no flag
    issue(2'd2, 5'd4, 32'h5, 32'h6, 16'h1, 24'h00_0008, 0, 32'hFFFF_FFF0, 4'd8, "R8 branch wrap");
    // R6 unaligned instruction address, R1 mode 3 also branch
    issue(2'd2, 5'd0, 32'h0, 32'h0, 16'h0, 24'h00_0001, 0, 32'h0000_2003, 4'd1, "R6 aligned");
    issue(2'd3, 5'd9, 32'h9, 32'h9, 16'h4, 24'h00_0010, 0, 32'h0000_1000, 4'd1, "R1 mode3 branch");
    idle(4);
    // R9 single pulse after isolated start
    issue(2'd0, 5'd5, 32'h0000_4000, 32'h0, 16'h0004, 24'h0, 0, 32'h0, 4'd2, "R9 isolated");
    idle(3);
    // R11 mid-run reset
    issue(2'd1, 5'd5, 32'hFFFF_FFF8, 32'h10, 16'h0, 24'h0, 0, 32'h0, 4'd8, "R7 pre-reset");
    idle(1);
    @(negedge clk);
    monOn = 0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(effAddr === 0 && !addrValid && !wrapFlag, "R11 mid-run reset",
          {30'd0, addrValid, wrapFlag, effAddr}, 64'd0);
    lastAddr = '0;
    lastWrap = 1'b0;
    monOn = 1;
    idle(2);
    @(negedge clk);
    check(expQ.size() == 0, "R9 all results delivered", 64'(expQ.size()), 64'd0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule